// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block models the command side of a byte-wide sector-erase flash memory of 512K by 8. Eight equal sectors are chosen by the top three bits of the 19-bit byte address. The block watches write strobes on a parallel bus with chip-select, write-enable and output-enable, all active low. It decodes the unlock-key command grammar and runs the resulting embedded program or erase for a set number of clock cycles.

To keep elaboration small, each sector stores only 2^LOC_W bytes, and the address offset bits above LOC_W alias onto them. Program and erase times, and the window in which further sector-erase commands join a pending erase, are cycle-count parameters. A simulation can therefore replace microsecond and second times with short ones.

While an embedded operation or the erase-queue window is active, every read returns a status byte instead of array data. Bit 7 of that byte is the complement of the data being written, and bits 6:0 are zero. When the operation ends, the true contents reappear. All bus inputs are taken to be synchronous to `clk`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every stored byte reads FFh, `rd_en` is low and no operation is pending.
- R2: The write sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then D@A programs location A. The stored byte becomes its old value ANDed with D. Key addresses are compared on address bits 14:0 only.
- R3: A write happens while chip-select and write-enable are both low. The address is taken in the first cycle of that overlap, and the data in its last cycle.
- R4: The sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h sets every byte of every sector to FFh.
- R5: The same five-write prefix followed by 30h to any address erases the sector named by address bits 18:16 to FFh.
- R6: A further 30h write arriving within WIN_CYC cycles of the previous one adds its sector to the pending erase and restarts the window. All queued sectors are erased together once the window runs out, and the other sectors keep their data.
- R7: While a program, an erase or the erase window is active, a read of any address returns {~d7, 7'b0}. Here d7 is bit 7 of the byte being programmed, or 1 for an erase.
- R8: After the final program write, status is returned for exactly PROG_CYC cycles, and the new data appears in the next cycle. An erase is busy for exactly ERASE_CYC cycles.
- R9: A write that does not match the next expected step of the grammar returns the decoder to the read state, and the array is left unchanged.
- R10: Writes made while a program or erase is running are ignored and cannot start a new command.
- R11: `rd_en` and `rd_data` are registered. They show a read in the cycle after chip-select and output-enable are low with write-enable high, and the data comes from sector addr[18:16], byte addr[LOC_W-1:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data or status byte |
| rd_en | output | 1 | Registered read-valid / output drive enable |

## Verification
The end of an embedded program and a status read can fall in the same clock edge. The completion edge updates the array and clears the busy flag, while the read register still samples the old busy state. The bench provokes this by holding chip-select low and dropping output-enable in the same cycle that the final program write closes. It then samples every cycle: the old byte first, then exactly PROG_CYC status bytes, then the ANDed result with no gap and no extra status cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UNLK1,
      ST_UNLK2,
      ST_PROG_ARM,
      ST_ERS_ARM,
      ST_ERS_UNLK1,
      ST_ERS_UNLK2,
      ST_ERS_WIN
   } seq_st_t;

   localparam int          KEY_AW  = 15;
   localparam logic [14:0] A_KEY1  = 15'h5555;
   localparam logic [14:0] A_KEY2  = 15'h2AAA;
   localparam logic [7:0]  C_KEY1  = 8'hAA;
   localparam logic [7:0]  C_KEY2  = 8'h55;
   localparam logic [7:0]  C_PROG  = 8'hA0;
   localparam logic [7:0]  C_ERASE = 8'h80;
   localparam logic [7:0]  C_CHIP  = 8'h10;
   localparam logic [7:0]  C_SECT  = 8'h30;

endpackage

// File: rtl/fl_bus_capture.sv
module fl_bus_capture #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              wr_ev,
   output logic [ADDR_W-1:0] ev_addr,
   output logic [7:0]        ev_data
);

   logic strb, strb_q;
   logic [ADDR_W-1:0] addr_l;
   logic [7:0]        data_l;

   // write window is the overlap of both strobes
   assign strb = ~ce_n & ~we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b0;
         addr_l <= '0;
         data_l <= '0;
      end else begin
         strb_q <= strb;
         if (strb && !strb_q) addr_l <= addr;
         if (strb)            data_l <= wdata;
      end
   end

   assign wr_ev   = strb_q & ~strb;
   assign ev_addr = addr_l;
   assign ev_data = data_l;

endmodule

// File: rtl/fl_cmd_seq.sv
module fl_cmd_seq
   import fl_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int SECT_W  = 3,
   parameter int WIN_CYC = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_ev,
   input  logic [ADDR_W-1:0]        ev_addr,
   input  logic [7:0]               ev_data,
   input  logic                     op_busy,
   output logic                     prog_go,
   output logic                     erase_go,
   output logic [(1<<SECT_W)-1:0]   erase_mask,
   output logic                     win_act,
   output seq_st_t                  st_o
);

   localparam int SECT_CNT = 1 << SECT_W;
   localparam int WIN_W    = $clog2(WIN_CYC + 1);

   seq_st_t              st, st_n;
   logic [SECT_CNT-1:0]  mask_q, mask_n;
   logic [WIN_W-1:0]     win_q, win_n;
   logic                 key1, key2;
   logic [SECT_CNT-1:0]  sect_bit;

   assign key1     = ev_addr[KEY_AW-1:0] == A_KEY1;
   assign key2     = ev_addr[KEY_AW-1:0] == A_KEY2;
   assign sect_bit = SECT_CNT'(1) << ev_addr[ADDR_W-1 -: SECT_W];

   always_comb begin
      st_n     = st;
      mask_n   = mask_q;
      win_n    = win_q;
      prog_go  = 1'b0;
      erase_go = 1'b0;
      unique case (st)
         ST_READ: begin
            if (wr_ev && !op_busy && key1 && ev_data == C_KEY1) st_n = ST_UNLK1;
         end
         ST_UNLK1: begin
            if (wr_ev) st_n = (key2 && ev_data == C_KEY2) ? ST_UNLK2 : ST_READ;
         end
         ST_UNLK2: begin
            if (wr_ev) begin
               if (key1 && ev_data == C_PROG)       st_n = ST_PROG_ARM;
               else if (key1 && ev_data == C_ERASE) st_n = ST_ERS_ARM;
               else                                 st_n = ST_READ;
            end
         end
         ST_PROG_ARM: begin
            if (wr_ev) begin
               prog_go = 1'b1;
               st_n    = ST_READ;
            end
         end
         ST_ERS_ARM: begin
            if (wr_ev) st_n = (key1 && ev_data == C_KEY1) ? ST_ERS_UNLK1 : ST_READ;
         end
         ST_ERS_UNLK1: begin
            if (wr_ev) st_n = (key2 && ev_data == C_KEY2) ? ST_ERS_UNLK2 : ST_READ;
         end
         ST_ERS_UNLK2: begin
            if (wr_ev) begin
               if (key1 && ev_data == C_CHIP) begin
                  erase_go = 1'b1;
                  st_n     = ST_READ;
               end else if (ev_data == C_SECT) begin
                  mask_n = sect_bit;
                  win_n  = WIN_W'(WIN_CYC - 1);
                  st_n   = ST_ERS_WIN;
               end else begin
                  st_n = ST_READ;
               end
            end
         end
         ST_ERS_WIN: begin
            if (wr_ev && ev_data == C_SECT) begin
               mask_n = mask_q | sect_bit;
               win_n  = WIN_W'(WIN_CYC - 1);
            end else if (win_q == '0) begin
               erase_go = 1'b1;
               mask_n   = '0;
               st_n     = ST_READ;
            end else begin
               win_n = win_q - 1'b1;
            end
         end
         default: st_n = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_READ;
         mask_q <= '0;
         win_q  <= '0;
      end else begin
         st     <= st_n;
         mask_q <= mask_n;
         win_q  <= win_n;
      end
   end

   assign erase_mask = (st == ST_ERS_WIN) ? mask_q : '1;
   assign win_act    = st == ST_ERS_WIN;
   assign st_o       = st;

endmodule

// File: rtl/fl_op_timer.sv
module fl_op_timer #(
   parameter int ADDR_W    = 19,
   parameter int SECT_CNT  = 8,
   parameter int PROG_CYC  = 24,
   parameter int ERASE_CYC = 60
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_go,
   input  logic                erase_go,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [7:0]          in_data,
   input  logic [SECT_CNT-1:0] in_mask,
   output logic                busy,
   output logic                done,
   output logic                is_erase,
   output logic                pol,
   output logic [ADDR_W-1:0]   tgt_addr,
   output logic [7:0]          tgt_data,
   output logic [SECT_CNT-1:0] tgt_mask
);

   localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   logic                busy_q, erase_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [7:0]          data_q;
   logic [SECT_CNT-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         erase_q <= 1'b0;
         cnt_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         mask_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (prog_go) begin
         busy_q  <= 1'b1;
         erase_q <= 1'b0;
         cnt_q   <= CNT_W'(PROG_CYC - 1);
         addr_q  <= in_addr;
         data_q  <= in_data;
      end else if (erase_go) begin
         busy_q  <= 1'b1;
         erase_q <= 1'b1;
         cnt_q   <= CNT_W'(ERASE_CYC - 1);
         mask_q  <= in_mask;
      end
   end

   assign busy     = busy_q;
   assign done     = busy_q && cnt_q == '0;
   assign is_erase = erase_q;
   assign pol      = erase_q | data_q[7];
   assign tgt_addr = addr_q;
   assign tgt_data = data_q;
   assign tgt_mask = mask_q;

endmodule

// File: rtl/fl_sector_store.sv
module fl_sector_store #(
   parameter int LOC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [LOC_W-1:0] wr_loc,
   input  logic [7:0]       wr_data,
   input  logic [LOC_W-1:0] rd_loc,
   output logic [7:0]       rd_byte
);

   localparam int LOC_CNT = 1 << LOC_W;

   logic [7:0] mem [LOC_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LOC_CNT; i++) mem[i] <= 8'hFF;
      end else if (clr) begin
         for (int i = 0; i < LOC_CNT; i++) mem[i] <= 8'hFF;
      end else if (wr_en) begin
         mem[wr_loc] <= mem[wr_loc] & wr_data;
      end
   end

   assign rd_byte = mem[rd_loc];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fl_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int SECT_W    = 3,
   parameter int LOC_W     = 4,
   parameter int PROG_CYC  = 24,
   parameter int ERASE_CYC = 60,
   parameter int WIN_CYC   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rd_data,
   output logic              rd_en
);

   localparam int SECT_CNT = 1 << SECT_W;

   if (ADDR_W < KEY_AW)             begin : g_bad_aw  $error("ADDR_W too small for key addresses"); end
   if (SECT_W + LOC_W > ADDR_W)     begin : g_bad_loc $error("SECT_W + LOC_W exceeds ADDR_W"); end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || WIN_CYC < 1)
                                    begin : g_bad_cyc $error("cycle counts must be positive"); end

   logic                wr_ev;
   logic [ADDR_W-1:0]   ev_addr;
   logic [7:0]          ev_data;
   logic                prog_go, erase_go, win_act;
   logic [SECT_CNT-1:0] erase_mask;
   seq_st_t             seq_st;
   logic                op_busy, op_done, op_erase, op_pol;
   logic [ADDR_W-1:0]   tgt_addr;
   logic [7:0]          tgt_data;
   logic [SECT_CNT-1:0] tgt_mask;
   logic [7:0]          sect_rd [SECT_CNT];
   logic [SECT_W-1:0]   tgt_sect, rd_sect;
   logic                rd_req, status_mode;
   logic [7:0]          rd_data_q;
   logic                rd_en_q;

   fl_bus_capture #(.ADDR_W(ADDR_W)) i_cap (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .wdata(wdata),
      .wr_ev(wr_ev), .ev_addr(ev_addr), .ev_data(ev_data)
   );

   fl_cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYC(WIN_CYC)) i_seq (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .ev_addr(ev_addr), .ev_data(ev_data),
      .op_busy(op_busy), .prog_go(prog_go), .erase_go(erase_go), .erase_mask(erase_mask),
      .win_act(win_act), .st_o(seq_st)
   );

   fl_op_timer #(.ADDR_W(ADDR_W), .SECT_CNT(SECT_CNT), .PROG_CYC(PROG_CYC),
                 .ERASE_CYC(ERASE_CYC)) i_tmr (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
      .in_addr(ev_addr), .in_data(ev_data), .in_mask(erase_mask),
      .busy(op_busy), .done(op_done), .is_erase(op_erase), .pol(op_pol),
      .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_mask(tgt_mask)
   );

   assign tgt_sect = tgt_addr[ADDR_W-1 -: SECT_W];
   assign rd_sect  = addr[ADDR_W-1 -: SECT_W];

   for (genvar s = 0; s < SECT_CNT; s++) begin : g_sect
      fl_sector_store #(.LOC_W(LOC_W)) i_store (
         .clk(clk), .rst_n(rst_n),
         .clr(op_done && op_erase && tgt_mask[s]),
         .wr_en(op_done && !op_erase && tgt_sect == SECT_W'(s)),
         .wr_loc(tgt_addr[LOC_W-1:0]), .wr_data(tgt_data),
         .rd_loc(addr[LOC_W-1:0]), .rd_byte(sect_rd[s])
      );
   end

   assign rd_req      = ~ce_n & ~oe_n & we_n;
   assign status_mode = op_busy | win_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en_q   <= 1'b0;
         rd_data_q <= '0;
      end else begin
         rd_en_q <= rd_req;
         if (!rd_req)          rd_data_q <= '0;
         else if (status_mode) rd_data_q <= {~(win_act | op_pol), 7'b0};
         else                  rd_data_q <= sect_rd[rd_sect];
      end
   end

   assign rd_data = rd_data_q;
   assign rd_en   = rd_en_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
   import fl_pkg::*;
#(
   parameter int SECT_CNT  = 8,
   parameter int PROG_CYC  = 24,
   parameter int ERASE_CYC = 60
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_busy,
   input logic                op_erase,
   input logic                win_act,
   input seq_st_t             seq_st,
   input logic                wr_ev,
   input logic [7:0]          ev_data,
   input logic                erase_go,
   input logic [SECT_CNT-1:0] erase_mask,
   input logic                rd_en,
   input logic [7:0]          rd_data
);

   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_len <= 0;
      else if (op_busy) busy_len <= busy_len + 1;
      else              busy_len <= 0;
   end

   // R7
   status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && $past(op_busy | win_act) |-> rd_data[6:0] == 7'b0);

   // R8
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(op_busy) |-> busy_len == (op_erase ? ERASE_CYC : PROG_CYC));

   // R10
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_busy |-> seq_st == ST_READ);

   // R9
   seq_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ev && seq_st == ST_UNLK1 && ev_data != C_KEY2 |=> seq_st == ST_READ);

   // R6
   erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> erase_mask != '0);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
   .SECT_CNT(SECT_CNT), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase), .win_act(win_act),
   .seq_st(seq_st), .wr_ev(wr_ev), .ev_data(ev_data), .erase_go(erase_go),
   .erase_mask(erase_mask), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

   localparam int PROG_CYC  = 24;
   localparam int ERASE_CYC = 60;
   localparam int WIN_CYC   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [18:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rd_data;
   logic        rd_en;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] model [128];

   always #5 clk = ~clk;

   flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)) i_flash_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_en(rd_en)
   );

   // kind[28:27]: 0 program, 1 read-compare, 2 sector erase, 3 chip erase
   localparam logic [28:0] VEC [10] = '{
      {2'd0, 19'h30005, 8'h5A},
      {2'd1, 19'h30005, 8'h00},
      {2'd0, 19'h30005, 8'h0F},
      {2'd1, 19'h30005, 8'h00},
      {2'd0, 19'h7000F, 8'h81},
      {2'd1, 19'h7FFFF, 8'h00},
      {2'd2, 19'h30000, 8'h00},
      {2'd1, 19'h30005, 8'h00},
      {2'd3, 19'h00000, 8'h00},
      {2'd1, 19'h7000F, 8'h00}
   };

   function automatic int idx(input logic [18:0] a);
      return int'({a[18:16], a[3:0]});
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_rd(input logic [18:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(posedge clk); #1 d = rd_data;
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic unlock2(input logic [7:0] c);
      bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55); bus_wr(19'h05555, c);
   endtask

   task automatic do_prog(input logic [18:0] a, input logic [7:0] d);
      unlock2(8'hA0); bus_wr(a, d);
      model[idx(a)] = model[idx(a)] & d;
      repeat (PROG_CYC + 4) @(negedge clk);
   endtask

   task automatic erase_prefix();
      unlock2(8'h80); bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55);
   endtask

   task automatic do_sect_erase(input logic [2:0] s);
      erase_prefix(); bus_wr({s, 16'h1234}, 8'h30);
      for (int i = 0; i < 16; i++) model[{s, i[3:0]}] = 8'hFF;
      repeat (WIN_CYC + ERASE_CYC + 8) @(negedge clk);
   endtask

   task automatic do_chip_erase();
      erase_prefix(); bus_wr(19'h05555, 8'h10);
      for (int i = 0; i < 128; i++) model[i] = 8'hFF;
      repeat (ERASE_CYC + 8) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      for (int i = 0; i < 128; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rd_en idle", rd_en, 1'b0);
      bus_rd(19'h00000, r); check("R1 erased byte s0", r, 8'hFF);
      bus_rd(19'h6000A, r); check("R1 erased byte s6", r, 8'hFF);

      // table walk: R2 R4 R5 R11
      foreach (VEC[v]) begin
         case (VEC[v][28:27])
            2'd0: do_prog(VEC[v][26:8], VEC[v][7:0]);
            2'd1: begin
               bus_rd(VEC[v][26:8], r);
               check($sformatf("R2/R4/R5/R11 vector %0d", v), r, model[idx(VEC[v][26:8])]);
            end
            2'd2: do_sect_erase(VEC[v][26:24]);
            default: do_chip_erase();
         endcase
      end

      // R8 completion edge meets a status read
      begin
         int bad = 0;
         unlock2(8'hA0);
         @(negedge clk); addr = 19'h20003; wdata = 8'h37; ce_n = 1'b0; we_n = 1'b0;
         @(negedge clk);
         @(negedge clk); we_n = 1'b1; oe_n = 1'b0;
         @(posedge clk); #1 check("R8 old data before start", rd_data, 8'hFF);
         for (int k = 1; k <= PROG_CYC; k++) begin
            @(posedge clk); #1 if (rd_data !== 8'h80) bad++;
         end
         check("R7/R8 status cycle mismatches", bad, 0);
         @(posedge clk); #1 check("R8 data right after busy", rd_data, 8'h37);
         @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
         model[idx(19'h20003)] = 8'h37;
      end

      // R3 capture: address at first overlap cycle, data at last
      unlock2(8'hA0);
      @(negedge clk); addr = 19'h10009; we_n = 1'b0;
      @(negedge clk); addr = 19'h10004; wdata = 8'hEE; ce_n = 1'b0;
      @(negedge clk); addr = 19'h10006; wdata = 8'h3C;
      @(negedge clk); ce_n = 1'b1;
      @(negedge clk); we_n = 1'b1;
      repeat (PROG_CYC + 4) @(negedge clk);
      bus_rd(19'h10004, r); check("R3 latched address gets last data", r, 8'h3C);
      bus_rd(19'h10006, r); check("R3 later address untouched", r, 8'hFF);
      bus_rd(19'h10009, r); check("R3 pre-overlap address untouched", r, 8'hFF);

      // R9 broken sequences
      bus_wr(19'h05555, 8'hAA); bus_wr(19'h01234, 8'h55);
      bus_wr(19'h05555, 8'hA0); bus_wr(19'h40002, 8'h00);
      repeat (PROG_CYC + 4) @(negedge clk);
      bus_rd(19'h40002, r); check("R9 wrong key address no program", r, 8'hFF);
      erase_prefix(); bus_wr(19'h20000, 8'h20);
      repeat (WIN_CYC + ERASE_CYC + 8) @(negedge clk);
      bus_rd(19'h20003, r); check("R9 wrong erase code no erase", r, 8'h37);
      do_prog(19'h40002, 8'h66);
      bus_rd(19'h40002, r); check("R9 decoder recovers", r, 8'h66);

      // R6 multi-sector queue, R7 status in window
      do_prog(19'h10001, 8'h11);
      do_prog(19'h50001, 8'h55);
      erase_prefix();
      bus_wr(19'h10000, 8'h30);
      bus_wr(19'h40000, 8'h30);
      bus_rd(19'h20003, r); check("R7 status during erase window", r, 8'h00);
      repeat (WIN_CYC + ERASE_CYC + 8) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         model[{3'd1, i[3:0]}] = 8'hFF;
         model[{3'd4, i[3:0]}] = 8'hFF;
      end
      bus_rd(19'h10001, r); check("R6 first queued sector", r, 8'hFF);
      bus_rd(19'h40002, r); check("R6 second queued sector", r, 8'hFF);
      bus_rd(19'h20003, r); check("R6 unqueued sector kept", r, model[idx(19'h20003)]);
      bus_rd(19'h50001, r); check("R6 other sector kept", r, 8'h55);

      // R10 writes during a running program are ignored
      unlock2(8'hA0); bus_wr(19'h60007, 8'hF0);
      model[idx(19'h60007)] = 8'hF0;
      unlock2(8'hA0); bus_wr(19'h60008, 8'h00);
      repeat (PROG_CYC + 4) @(negedge clk);
      bus_rd(19'h60008, r); check("R10 write during busy ignored", r, 8'hFF);
      bus_rd(19'h60007, r); check("R10 running program completes", r, 8'hF0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule